// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit for a small 16-bit, word-addressed machine whose registers, ALU and memory share one bus. It advances one microstate per clock through a three-state fetch, a single decode state and a fixed execute sequence chosen by the 4-bit opcode in the instruction register. Each microstate drives a flat control word that holds the register load enables, the bus gate enables, the mux selects and the memory enable and write-enable lines. The datapath, the ALU and the memory array sit outside the block.

The control word depends only on the current state, so the word seen during a state stays the same for the whole state. Any state that drives the memory enable stays put until `mem_ready` is high. An opcode outside the supported set, including the reserved code 1101, sends the sequencer to a halt state. Only a reset leaves that state.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is the first fetch state, with `ctrl_word` = 0x00049 and `halted` = 0. The control word bits are: [0] load address reg, [1] load data reg, [2] load instruction reg, [3] load PC, [4] load dest reg, [5] load cond codes, [6] gate PC, [7] gate data reg, [8] gate ALU, [9] gate address adder, [10] mem enable, [11] mem write, [13:12] PC select (0 = +1, 1 = bus, 2 = address adder), [14] address base (1 = base reg, 0 = PC), [15] data reg input from bus, [17:16] offset select (0 = zero, 1 = 6-bit, 2 = 9-bit).
- R2: Fetch takes three states, 0x00049 (PC to the address reg, PC incremented), 0x00402 (memory read into the data reg) and 0x00084 (data reg to the instruction reg). A decode state with word 0x00000 follows. Decode branches on the opcode.
- R3: Opcodes 0001, 0101 and 1001 execute in one state, 0x00130, and then return to fetch.
- R4: Opcode 0010 executes 0x20201, 0x00402, 0x000B0. Opcode 0110 executes 0x14201, 0x00402, 0x000B0.
- R5: Opcode 1010 executes five states: 0x20201, 0x00402, 0x00081 (data reg copied to the address reg), 0x00402, 0x000B0.
- R6: Opcode 1110 executes one state, 0x20210, with no memory access.
- R7: Opcode 0011 executes 0x20201, 0x08102, 0x00C00. Opcode 0111 executes 0x14201, 0x08102, 0x00C00.
- R8: Opcode 1011 executes five states: 0x20201, 0x00402, 0x00081, 0x08102, 0x00C00.
- R9: Opcode 1100 executes one state, 0x06008, which loads the PC from the base register through the adder.
- R10: A state with mem enable set repeats while `mem_ready` is low. `mem_ready` has no effect in other states.
- R11: At most one gate bit (6 to 9) is set in any state. Mem write is never set without mem enable.
- R12: Opcodes 0000, 0100, 1000, 1101 and 1111 lead from decode to a halt state with `ctrl_word` = 0 and `halted` = 1. The halt state ignores `opcode` and `mem_ready` and is left only through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Bits [15:12] of the instruction register |
| mem_ready | input | 1 | Memory has completed the current access |
| ctrl_word | output | 18 | Control word for the current microstate |
| halted | output | 1 | Sequencer is in the halt state |

## Verification
The assertions assume that `opcode` holds its value from decode to the end of execute, because the instruction register is only reloaded during fetch. They also assume that `mem_ready` is only meaningful during memory states. The stimulus changes `opcode` only in fetch states or in halt. It holds `mem_ready` low for whole stretches of memory states to create stalls. It also drives `mem_ready` low in non-memory states to show that the input is ignored there.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [4:0] {
        S_F1, S_F2, S_F3, S_DEC,
        S_ALU, S_EA_PC, S_EA_BASE, S_RD1, S_IND, S_RD2, S_WB,
        S_LEA, S_STD, S_STW, S_JMP, S_HALT
    } state_e;

    typedef enum logic [1:0] {PCS_INC = 2'd0, PCS_BUS = 2'd1, PCS_ADDER = 2'd2} pc_sel_e;
    typedef enum logic [1:0] {OFS_ZERO = 2'd0, OFS_6 = 2'd1, OFS_9 = 2'd2} off_sel_e;

    typedef struct packed {
        off_sel_e off_sel;     // [17:16]
        logic     mdr_src_bus; // [15]
        logic     addr_base;   // [14]
        pc_sel_e  pc_sel;      // [13:12]
        logic     mem_we;      // [11]
        logic     mem_en;      // [10]
        logic     gate_addr;   // [9]
        logic     gate_alu;    // [8]
        logic     gate_mdr;    // [7]
        logic     gate_pc;     // [6]
        logic     ld_cc;       // [5]
        logic     ld_reg;      // [4]
        logic     ld_pc;       // [3]
        logic     ld_ir;       // [2]
        logic     ld_mdr;      // [1]
        logic     ld_mar;      // [0]
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [3:0] {
        OC_ALU, OC_LD_PC, OC_LD_BASE, OC_LD_IND, OC_LEA,
        OC_ST_PC, OC_ST_BASE, OC_ST_IND, OC_JMP, OC_BAD
    } op_class_e;

    function automatic op_class_e classify(input logic [OPC_W-1:0] op);
        case (op)
            4'b0001, 4'b0101, 4'b1001: return OC_ALU;
            4'b0010: return OC_LD_PC;
            4'b0110: return OC_LD_BASE;
            4'b1010: return OC_LD_IND;
            4'b1110: return OC_LEA;
            4'b0011: return OC_ST_PC;
            4'b0111: return OC_ST_BASE;
            4'b1011: return OC_ST_IND;
            4'b1100: return OC_JMP;
            default: return OC_BAD;
        endcase
    endfunction

    function automatic logic is_store(input op_class_e c);
        return (c == OC_ST_PC) || (c == OC_ST_BASE) || (c == OC_ST_IND);
    endfunction

    function automatic logic is_indirect(input op_class_e c);
        return (c == OC_LD_IND) || (c == OC_ST_IND);
    endfunction

endpackage

// File: rtl/useq_next_state.sv
module useq_next_state
    import useq_pkg::*;
(
    input  state_e             cur,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               mem_ready,
    output state_e             nxt
);
    op_class_e cls;

    always_comb begin
        cls = classify(opcode);
        nxt = cur;
        case (cur)
            S_F1:  nxt = S_F2;
            S_F2:  nxt = mem_ready ? S_F3 : S_F2;
            S_F3:  nxt = S_DEC;
            S_DEC: begin
                case (cls)
                    OC_ALU:                         nxt = S_ALU;
                    OC_LD_PC, OC_LD_IND,
                    OC_ST_PC, OC_ST_IND:            nxt = S_EA_PC;
                    OC_LD_BASE, OC_ST_BASE:         nxt = S_EA_BASE;
                    OC_LEA:                         nxt = S_LEA;
                    OC_JMP:                         nxt = S_JMP;
                    default:                        nxt = S_HALT;
                endcase
            end
            S_EA_PC, S_EA_BASE:
                nxt = (is_store(cls) && !is_indirect(cls)) ? S_STD : S_RD1;
            S_RD1: begin
                if (mem_ready) nxt = is_indirect(cls) ? S_IND : S_WB;
            end
            S_IND: nxt = is_store(cls) ? S_STD : S_RD2;
            S_RD2: nxt = mem_ready ? S_WB : S_RD2;
            S_STD: nxt = S_STW;
            S_STW: nxt = mem_ready ? S_F1 : S_STW;
            S_WB, S_ALU, S_LEA, S_JMP: nxt = S_F1;
            S_HALT: nxt = S_HALT;
            default: nxt = S_HALT;
        endcase
    end
endmodule

// File: rtl/useq_ctrl_decode.sv
module useq_ctrl_decode
    import useq_pkg::*;
(
    input  state_e cur,
    output ctrl_t  cw
);
    always_comb begin
        cw = '0;
        case (cur)
            S_F1: begin
                cw.gate_pc = 1'b1;
                cw.ld_mar  = 1'b1;
                cw.ld_pc   = 1'b1;
                cw.pc_sel  = PCS_INC;
            end
            S_F2, S_RD1, S_RD2: begin
                cw.mem_en = 1'b1;
                cw.ld_mdr = 1'b1;
            end
            S_F3: begin
                cw.gate_mdr = 1'b1;
                cw.ld_ir    = 1'b1;
            end
            S_ALU: begin
                cw.gate_alu = 1'b1;
                cw.ld_reg   = 1'b1;
                cw.ld_cc    = 1'b1;
            end
            S_EA_PC: begin
                cw.gate_addr = 1'b1;
                cw.ld_mar    = 1'b1;
                cw.off_sel   = OFS_9;
            end
            S_EA_BASE: begin
                cw.gate_addr = 1'b1;
                cw.ld_mar    = 1'b1;
                cw.addr_base = 1'b1;
                cw.off_sel   = OFS_6;
            end
            S_IND: begin
                cw.gate_mdr = 1'b1;
                cw.ld_mar   = 1'b1;
            end
            S_WB: begin
                cw.gate_mdr = 1'b1;
                cw.ld_reg   = 1'b1;
                cw.ld_cc    = 1'b1;
            end
            S_LEA: begin
                cw.gate_addr = 1'b1;
                cw.ld_reg    = 1'b1;
                cw.off_sel   = OFS_9;
            end
            S_STD: begin
                cw.gate_alu    = 1'b1;
                cw.ld_mdr      = 1'b1;
                cw.mdr_src_bus = 1'b1;
            end
            S_STW: begin
                cw.mem_en = 1'b1;
                cw.mem_we = 1'b1;
            end
            S_JMP: begin
                cw.ld_pc     = 1'b1;
                cw.pc_sel    = PCS_ADDER;
                cw.addr_base = 1'b1;
                cw.off_sel   = OFS_ZERO;
            end
            default: cw = '0;
        endcase
    end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
    import useq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OPC_W-1:0]    opcode,
    input  logic                mem_ready,
    output logic [CTRL_W-1:0]   ctrl_word,
    output logic                halted
);
    state_e state, state_nxt;
    ctrl_t  cw;

    useq_next_state u_next (
        .cur       (state),
        .opcode    (opcode),
        .mem_ready (mem_ready),
        .nxt       (state_nxt)
    );

    useq_ctrl_decode u_ctrl (
        .cur (state),
        .cw  (cw)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= S_F1;
        else     state <= state_nxt;
    end

    assign ctrl_word = cw;
    assign halted    = (state == S_HALT);

    // R11: single bus driver, write only with enable
    assert_one_gate_R11: assert property (@(posedge clk) disable iff (rst)
        $countones({cw.gate_pc, cw.gate_mdr, cw.gate_alu, cw.gate_addr}) <= 1);
    assert_we_with_en_R11: assert property (@(posedge clk) disable iff (rst)
        cw.mem_we |-> cw.mem_en);
    // R10: memory states hold until ready
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (cw.mem_en && !mem_ready) |=> $stable(state));
    // R12: reserved opcode halts, halt is sticky
    assert_reserved_halt_R12: assert property (@(posedge clk) disable iff (rst)
        (state == S_DEC && opcode == 4'b1101) |=> halted);
    assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);
    // R2: fetch ordering
    assert_fetch_start_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_F1) |=> (state == S_F2));
    assert_ir_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
        cw.ld_ir |=> (state == S_DEC));
endmodule

// File: tb/sim_ucode_sequencer.sv
module sim_ucode_sequencer;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        rst;
        logic        rdy;
        logic [3:0]  opc;
        logic [17:0] ctrl;
        logic        halt;
        logic [31:0] tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode = 4'h0;
    logic        mem_ready = 1'b0;
    logic [17:0] ctrl_word;
    logic        halted;

    item_t q[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ucode_sequencer u0 (
        .clk(clk), .rst(rst), .opcode(opcode), .mem_ready(mem_ready),
        .ctrl_word(ctrl_word), .halted(halted)
    );

    task automatic push(input logic r, input logic rd, input logic [3:0] op,
                        input logic [17:0] c, input logic h, input logic [31:0] t);
        item_t it;
        it.rst = r; it.rdy = rd; it.opc = op; it.ctrl = c; it.halt = h; it.tag = t;
        q.push_back(it);
    endtask

    // memory state: stall cycles with ready low (R10), then one with ready high
    task automatic push_mem(input logic [3:0] op, input logic [17:0] c,
                            input int stall, input logic [31:0] t);
        for (int i = 0; i < stall; i++) push(1'b0, 1'b0, op, c, 1'b0, "R10");
        push(1'b0, 1'b1, op, c, 1'b0, t);
    endtask

    task automatic push_fetch(input logic [3:0] op, input int stall);
        push(1'b0, 1'b0, op, 18'h00049, 1'b0, "R2");
        push_mem(op, 18'h00402, stall, "R2");
        push(1'b0, 1'b0, op, 18'h00084, 1'b0, "R2");
        push(1'b0, 1'b0, op, 18'h00000, 1'b0, "R2");
    endtask

    task automatic push_instr(input logic [3:0] op, input int stall);
        push_fetch(op, stall);
        case (op)
            4'b0001, 4'b0101, 4'b1001: push(1'b0, 1'b0, op, 18'h00130, 1'b0, "R3");
            4'b0010, 4'b0110: begin
                push(1'b0, 1'b0, op, (op == 4'b0010) ? 18'h20201 : 18'h14201, 1'b0, "R4");
                push_mem(op, 18'h00402, stall, "R4");
                push(1'b0, 1'b0, op, 18'h000B0, 1'b0, "R4");
            end
            4'b1010: begin
                push(1'b0, 1'b0, op, 18'h20201, 1'b0, "R5");
                push_mem(op, 18'h00402, stall, "R5");
                push(1'b0, 1'b0, op, 18'h00081, 1'b0, "R5");
                push_mem(op, 18'h00402, stall, "R5");
                push(1'b0, 1'b0, op, 18'h000B0, 1'b0, "R5");
            end
            4'b1110: push(1'b0, 1'b0, op, 18'h20210, 1'b0, "R6");
            4'b0011, 4'b0111: begin
                push(1'b0, 1'b0, op, (op == 4'b0011) ? 18'h20201 : 18'h14201, 1'b0, "R7");
                push(1'b0, 1'b0, op, 18'h08102, 1'b0, "R7");
                push_mem(op, 18'h00C00, stall, "R11");
            end
            4'b1011: begin
                push(1'b0, 1'b0, op, 18'h20201, 1'b0, "R8");
                push_mem(op, 18'h00402, stall, "R8");
                push(1'b0, 1'b0, op, 18'h00081, 1'b0, "R8");
                push(1'b0, 1'b0, op, 18'h08102, 1'b0, "R8");
                push_mem(op, 18'h00C00, stall, "R8");
            end
            4'b1100: push(1'b0, 1'b0, op, 18'h06008, 1'b0, "R9");
            default: begin
                // R12: halt, inputs ignored, then reset releases it
                push(1'b0, 1'b0, op,      18'h0, 1'b1, "R12");
                push(1'b0, 1'b1, 4'b0001, 18'h0, 1'b1, "R12");
                push(1'b0, 1'b0, 4'b0010, 18'h0, 1'b1, "R12");
                push(1'b0, 1'b1, 4'b1100, 18'h0, 1'b1, "R12");
                push(1'b1, 1'b0, 4'b0001, 18'h0, 1'b1, "R12");
                push(1'b0, 1'b0, 4'b0001, 18'h00049, 1'b0, "R1");
                q.pop_back(); // next fetch supplies this state
            end
        endcase
    endtask

    // driver: builds the whole expected trace
    initial begin
        push(1'b1, 1'b0, 4'h1, 18'h00049, 1'b0, "R1");
        push(1'b1, 1'b1, 4'h1, 18'h00049, 1'b0, "R1");
        push_instr(4'b0001, 0);
        push_instr(4'b0101, 1);
        push_instr(4'b1001, 0);
        push_instr(4'b0010, 2);
        push_instr(4'b0110, 0);
        push_instr(4'b1010, 1);
        push_instr(4'b1110, 0);
        push_instr(4'b0011, 1);
        push_instr(4'b0111, 0);
        push_instr(4'b1011, 2);
        push_instr(4'b1100, 0);
        push_instr(4'b1101, 0);
        push_instr(4'b0000, 1);
        push_instr(4'b1111, 0);
        push_instr(4'b0100, 0);
        push_instr(4'b1000, 0);
        push_instr(4'b0001, 0);
    end

    // monitor: one item per cycle, sampled at the falling edge
    initial begin
        item_t it;
        repeat (3) @(posedge clk);
        @(negedge clk);
        while (q.size() > 0) begin
            it = q.pop_front();
            rst = it.rst;
            mem_ready = it.rdy;
            opcode = it.opc;
            n_run++;
            if (ctrl_word !== it.ctrl || halted !== it.halt) begin
                n_fail++;
                $display("FAIL %s: ctrl_word=%h halted=%b expected ctrl_word=%h halted=%b",
                         it.tag, ctrl_word, halted, it.ctrl, it.halt);
            end
            @(negedge clk);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, got no end expected end");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule